// File: doc/BRIEF.md
# Kernel-to-user halfword store unit

This block decodes and executes one compressed-format store-halfword instruction. A kernel uses it to write a 16-bit value into the user virtual address space. The request carries the following inputs:

- the 32-bit instruction word;
- the base and source register values;
- the privilege mode and a feature-enable bit;
- the CPU and reverse endian controls;
- the access-mode code of the target segment;
- two alignment policy bits.

One clock after a request, the block returns a registered response. The response holds the effective address and the translation-space select (user mapping or normal mapping). It also holds the low physical address bits after the endian swap, and the store data placed in its byte lanes with matching byte enables. A store request is raised only when no exception applies. Otherwise exactly one exception flag is raised, chosen by priority.

Address translation, the memory system, watch logic and bus errors live outside this block. The translation select and the physical low-bit adjustment are outputs for that logic to use.

Top module: `khs_store_unit`

## Requirements
- R1: An instruction matches when bits [31:26] = 6'b011000, bits [15:12] = 4'b1010 and bits [11:9] = 3'b101. A non-matching word gives `dec_hit`=0, no store and no exception flag. A response (`rsp_valid`=1) appears exactly one clock after a cycle with `req_valid`=1, and only then.
- R2: `eff_addr` equals `base_val` plus the 9-bit offset in instr[8:0], sign-extended to the full address width.
- R3: A matching instruction with `feat_en`=0 raises `exc_resv`.
- R4: A matching instruction raises `exc_priv` when `kernel_mode`=0, or when `seg_mode` is not 1, 2 or 3. Here 1 means a user-mapped kernel-visible segment, 2 means a mapped shared segment and 3 means an unmapped shared segment.
- R5: On a store, `xlat_user` is 1 exactly when `seg_mode`=1. It is 0 for modes 2 and 3, and 0 whenever `st_req`=0.
- R6: With `misalign_ok`=0, an odd `eff_addr` raises `exc_align` and issues no store.
- R7: The lane is eff_addr[2:0] XOR {big_endian,2'b00}. `byte_en` has bits lane and lane+1 set. `st_data` is `rt_val` shifted left by 8×lane.
- R8: `paddr_lo` equals eff_addr[2:0] XOR {rev_endian,2'b00}.
- R9: At lane 7, with `misalign_ok`=1, the behaviour depends on `wrap_en`. If `wrap_en`=1, `byte_en`=8'h81 and st_data[7:0] = rt_val[15:8]. If `wrap_en`=0, `byte_en`=8'h80 and `split_acc`=1.
- R10: Exceptions are ranked with `exc_resv` first, then `exc_priv`, then `exc_align`. At most one flag is raised. `st_req`=1 only when no flag is raised, and `byte_en` is 0 when `st_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| base_val | input | 64 | Base register value |
| rt_val | input | 64 | Source register value |
| kernel_mode | input | 1 | 1 when executing in kernel mode |
| feat_en | input | 1 | Feature enable configuration bit |
| seg_mode | input | 3 | Target segment access-mode code |
| big_endian | input | 1 | CPU big-endian mode |
| rev_endian | input | 1 | Reverse endian for the current mode |
| misalign_ok | input | 1 | Hardware misalignment support |
| wrap_en | input | 1 | Lane-7 access wraps inside the doubleword |
| rsp_valid | output | 1 | Response valid |
| dec_hit | output | 1 | Instruction matched |
| st_req | output | 1 | Store request issued |
| eff_addr | output | 64 | Effective virtual address |
| xlat_user | output | 1 | Translate with the user mapping |
| paddr_lo | output | 3 | Physical address low bits after endian swap |
| byte_en | output | 8 | Byte enables |
| st_data | output | 64 | Lane-positioned store data |
| split_acc | output | 1 | Access crosses the doubleword edge |
| exc_resv | output | 1 | Reserved-instruction exception |
| exc_priv | output | 1 | Privilege exception |
| exc_align | output | 1 | Address-alignment exception |

## Verification
The hardest case to reach is the lane-7 case, in both its wrapped and split forms. It needs three conditions at once: `misalign_ok` set, an odd effective address, and a lane index of seven after the big-endian XOR. The stimulus reaches lane 7 in two ways. One is an address ending in 7 with little-endian order. The other is an address ending in 3 with big-endian order, where a negative offset carries the sum down from an aligned base. The exception ranking is checked by raising all three causes together and then removing them one at a time.

// File: rtl/khs_pkg.sv
package khs_pkg;
  localparam logic [5:0] MAJOR_OP = 6'b011000;
  localparam logic [3:0] MINOR_OP = 4'b1010;
  localparam logic [2:0] SUB_OP   = 3'b101;
  localparam int         OFF_W    = 9;
  localparam int         LANES    = 8;

  localparam logic [2:0] SEG_USER_MAP   = 3'd1;
  localparam logic [2:0] SEG_MAP_SHARED = 3'd2;
  localparam logic [2:0] SEG_FLAT_SHARE = 3'd3;

  // two adjacent lanes from lane; lane 7 wraps to lane 0 only when asked
  function automatic logic [LANES-1:0] pair_mask(input logic [2:0] lane, input logic wrap);
    logic [LANES-1:0] m;
    m = '0;
    m[lane] = 1'b1;
    if (lane != 3'd7) m[lane + 3'd1] = 1'b1;
    else if (wrap)    m[0] = 1'b1;
    return m;
  endfunction

  function automatic logic seg_allowed(input logic [2:0] mode);
    return (mode == SEG_USER_MAP) || (mode == SEG_MAP_SHARED) || (mode == SEG_FLAT_SHARE);
  endfunction
endpackage

// File: rtl/khs_decode.sv
module khs_decode
  import khs_pkg::*;
(
  input  logic [31:0]      instr,
  output logic             hit,
  output logic [OFF_W-1:0] off
);
  assign hit = (instr[31:26] == MAJOR_OP) && (instr[15:12] == MINOR_OP) && (instr[11:9] == SUB_OP);
  assign off = instr[OFF_W-1:0];
endmodule

// File: rtl/khs_addr.sv
module khs_addr
  import khs_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] off,
  input  logic             big_endian,
  input  logic             rev_endian,
  output logic [XLEN-1:0]  eaddr,
  output logic [2:0]       lane,
  output logic [2:0]       paddr_lo
);
  function automatic logic [XLEN-1:0] sext_off(input logic [OFF_W-1:0] o);
    return {{(XLEN-OFF_W){o[OFF_W-1]}}, o};
  endfunction

  assign eaddr    = base + sext_off(off);
  assign lane     = eaddr[2:0] ^ {big_endian, 2'b00};
  assign paddr_lo = eaddr[2:0] ^ {rev_endian, 2'b00};
endmodule

// File: rtl/khs_lane.sv
module khs_lane
  import khs_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]  rt,
  input  logic [2:0]       lane,
  input  logic             wrap_en,
  output logic [XLEN-1:0]  data,
  output logic [LANES-1:0] be,
  output logic             split
);
  localparam int SHW = $clog2(XLEN);

  always_comb begin
    data = rt << {{(SHW-3){1'b0}}, lane, 3'b000};
    if (lane == 3'd7 && wrap_en) data[7:0] = rt[15:8];
  end

  assign be    = pair_mask(lane, wrap_en);
  assign split = (lane == 3'd7) && !wrap_en;
endmodule

// File: rtl/khs_except.sv
module khs_except
  import khs_pkg::*;
(
  input  logic       hit,
  input  logic       feat_en,
  input  logic       kernel_mode,
  input  logic [2:0] seg_mode,
  input  logic       misalign_ok,
  input  logic       addr_odd,
  output logic       e_resv,
  output logic       e_priv,
  output logic       e_align,
  output logic       go
);
  logic c_resv, c_priv, c_align;
  assign c_resv  = !feat_en;
  assign c_priv  = !kernel_mode || !seg_allowed(seg_mode);
  assign c_align = !misalign_ok && addr_odd;

  assign e_resv  = hit && c_resv;
  assign e_priv  = hit && !c_resv && c_priv;
  assign e_align = hit && !c_resv && !c_priv && c_align;
  assign go      = hit && !c_resv && !c_priv && !c_align;
endmodule

// File: rtl/khs_store_unit.sv
module khs_store_unit
  import khs_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [31:0]      instr,
  input  logic [XLEN-1:0]  base_val,
  input  logic [XLEN-1:0]  rt_val,
  input  logic             kernel_mode,
  input  logic             feat_en,
  input  logic [2:0]       seg_mode,
  input  logic             big_endian,
  input  logic             rev_endian,
  input  logic             misalign_ok,
  input  logic             wrap_en,
  output logic             rsp_valid,
  output logic             dec_hit,
  output logic             st_req,
  output logic [XLEN-1:0]  eff_addr,
  output logic             xlat_user,
  output logic [2:0]       paddr_lo,
  output logic [LANES-1:0] byte_en,
  output logic [XLEN-1:0]  st_data,
  output logic             split_acc,
  output logic             exc_resv,
  output logic             exc_priv,
  output logic             exc_align
);
  logic             w_hit, w_go, w_er, w_ep, w_ea, w_split;
  logic [OFF_W-1:0] w_off;
  logic [XLEN-1:0]  w_ea_addr, w_data;
  logic [2:0]       w_lane, w_plo;
  logic [LANES-1:0] w_be;

  khs_decode u_dec (.instr(instr), .hit(w_hit), .off(w_off));

  khs_addr #(.XLEN(XLEN)) u_addr (
    .base(base_val), .off(w_off), .big_endian(big_endian), .rev_endian(rev_endian),
    .eaddr(w_ea_addr), .lane(w_lane), .paddr_lo(w_plo)
  );

  khs_lane #(.XLEN(XLEN)) u_lane (
    .rt(rt_val), .lane(w_lane), .wrap_en(wrap_en),
    .data(w_data), .be(w_be), .split(w_split)
  );

  khs_except u_exc (
    .hit(w_hit), .feat_en(feat_en), .kernel_mode(kernel_mode), .seg_mode(seg_mode),
    .misalign_ok(misalign_ok), .addr_odd(w_ea_addr[0]),
    .e_resv(w_er), .e_priv(w_ep), .e_align(w_ea), .go(w_go)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      dec_hit   <= 1'b0;
      st_req    <= 1'b0;
      eff_addr  <= '0;
      xlat_user <= 1'b0;
      paddr_lo  <= '0;
      byte_en   <= '0;
      st_data   <= '0;
      split_acc <= 1'b0;
      exc_resv  <= 1'b0;
      exc_priv  <= 1'b0;
      exc_align <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      dec_hit   <= req_valid && w_hit;
      st_req    <= req_valid && w_go;
      eff_addr  <= w_ea_addr;
      xlat_user <= req_valid && w_go && (seg_mode == SEG_USER_MAP);
      paddr_lo  <= w_plo;
      byte_en   <= (req_valid && w_go) ? w_be : '0;
      st_data   <= w_data;
      split_acc <= req_valid && w_go && w_split;
      exc_resv  <= req_valid && w_er;
      exc_priv  <= req_valid && w_ep;
      exc_align <= req_valid && w_ea;
    end
  end

  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !dec_hit) |-> !(st_req || exc_resv || exc_priv || exc_align));
  a_r10_one_exc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exc_resv, exc_priv, exc_align}));
  a_r10_store_clean: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> !(exc_resv || exc_priv || exc_align));
  a_r7_two_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_req && !split_acc) |-> ($countones(byte_en) == 2));
  a_r9_split_edge: assert property (@(posedge clk) disable iff (!rst_n)
    split_acc |-> (byte_en == 8'h80));
  a_r5_xlat_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_user |-> st_req);
endmodule

// File: tb/khs_store_unit_bench.sv
module khs_store_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] base_val = '0, rt_val = '0;
  logic        kernel_mode = 1'b0, feat_en = 1'b0;
  logic [2:0]  seg_mode = '0;
  logic        big_endian = 1'b0, rev_endian = 1'b0, misalign_ok = 1'b0, wrap_en = 1'b0;
  logic        rsp_valid, dec_hit, st_req, xlat_user, split_acc, exc_resv, exc_priv, exc_align;
  logic [63:0] eff_addr, st_data;
  logic [2:0]  paddr_lo;
  logic [7:0]  byte_en;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  khs_store_unit u_khs_store_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr(instr),
    .base_val(base_val), .rt_val(rt_val), .kernel_mode(kernel_mode), .feat_en(feat_en),
    .seg_mode(seg_mode), .big_endian(big_endian), .rev_endian(rev_endian),
    .misalign_ok(misalign_ok), .wrap_en(wrap_en), .rsp_valid(rsp_valid), .dec_hit(dec_hit),
    .st_req(st_req), .eff_addr(eff_addr), .xlat_user(xlat_user), .paddr_lo(paddr_lo),
    .byte_en(byte_en), .st_data(st_data), .split_acc(split_acc), .exc_resv(exc_resv),
    .exc_priv(exc_priv), .exc_align(exc_align)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [8:0] off, input logic [4:0] rt = 5'd3, input logic [4:0] bs = 5'd4);
    return {6'b011000, rt, bs, 4'b1010, 3'b101, off};
  endfunction

  // drive one request, model the expected response, compare every output
  task automatic run(input string tag, input logic [31:0] ins, input logic [63:0] b, input logic [63:0] r,
                     input logic km, input logic fe, input logic [2:0] sm, input logic bge,
                     input logic rve, input logic mok, input logic wr);
    logic hit, e_r, e_p, e_a, go;
    logic [63:0] ea, dexp;
    logic [2:0] ln;
    logic [7:0] bexp;
    @(negedge clk);
    instr = ins; base_val = b; rt_val = r; kernel_mode = km; feat_en = fe; seg_mode = sm;
    big_endian = bge; rev_endian = rve; misalign_ok = mok; wrap_en = wr; req_valid = 1'b1;
    hit = (ins[31:26] == 6'o30) && (ins[15:9] == 7'b1010101);
    ea  = b + 64'($signed(ins[8:0]));
    ln  = {ea[2] ^ bge, ea[1:0]};
    e_r = hit && !fe;
    e_p = hit && fe && (!km || sm == 3'd0 || sm > 3'd3);
    e_a = hit && !e_r && !e_p && !mok && ea[0];
    go  = hit && !e_r && !e_p && !e_a;
    bexp = '0;
    for (int i = 0; i < 8; i++)
      if (go && (i == int'(ln) || i == int'(ln) + 1 || (ln == 3'd7 && wr && i == 0))) bexp[i] = 1'b1;
    dexp = r * (64'd1 << (8 * int'(ln)));
    if (ln == 3'd7 && wr) dexp[7:0] = r[15:8];
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, "rsp_valid (R1)", 64'(rsp_valid), 64'd1);
    chk(tag, "dec_hit (R1)", 64'(dec_hit), 64'(hit));
    chk(tag, "exc_resv (R3)", 64'(exc_resv), 64'(e_r));
    chk(tag, "exc_priv (R4)", 64'(exc_priv), 64'(e_p));
    chk(tag, "exc_align (R6)", 64'(exc_align), 64'(e_a));
    chk(tag, "st_req (R10)", 64'(st_req), 64'(go));
    chk(tag, "byte_en (R7)", 64'(byte_en), 64'(bexp));
    if (hit) begin
      chk(tag, "eff_addr (R2)", eff_addr, ea);
      chk(tag, "paddr_lo (R8)", 64'(paddr_lo), 64'(ea[2:0] ^ {rve, 2'b00}));
    end
    chk(tag, "xlat_user (R5)", 64'(xlat_user), 64'(go && sm == 3'd1));
    chk(tag, "split_acc (R9)", 64'(split_acc), 64'(go && ln == 3'd7 && !wr));
    if (go) chk(tag, "st_data (R7)", st_data, dexp);
    @(negedge clk);
    chk(tag, "rsp drops (R1)", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 reset", "rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R10 reset", "st_req", 64'(st_req), 64'd0);
    chk("R10 reset", "byte_en", 64'(byte_en), 64'd0);
  endtask

  task automatic t_basic;
    run("R2 R7 basic", mk(9'd4), 64'h1000, 64'h1122_3344_5566_A1B2, 1, 1, 3'd2, 0, 0, 0, 0);
    run("R2 negative offset", mk(9'h1FE), 64'h2000, 64'hBEEF, 1, 1, 3'd3, 0, 0, 0, 0);
    run("R2 carry", mk(9'h0FF), 64'hFFFF_FFFF_FFFF_FF01, 64'h55AA, 1, 1, 3'd2, 0, 0, 0, 0);
  endtask

  task automatic t_xlat;
    run("R5 user map", mk(9'd2), 64'h3000, 64'h1234, 1, 1, 3'd1, 0, 0, 0, 0);
    run("R5 flat", mk(9'd2), 64'h3000, 64'h1234, 1, 1, 3'd3, 0, 0, 0, 0);
  endtask

  task automatic t_endian;
    run("R7 R8 big", mk(9'd2), 64'h4000, 64'hCAFE, 1, 1, 3'd2, 1, 0, 0, 0);
    run("R8 reverse", mk(9'd6), 64'h4000, 64'hCAFE, 1, 1, 3'd2, 0, 1, 0, 0);
    run("R7 R8 both", mk(9'd0), 64'h4000, 64'hCAFE, 1, 1, 3'd1, 1, 1, 0, 0);
  endtask

  task automatic t_exc;
    run("R3 disabled", mk(9'd0), 64'h100, 64'h1, 1, 0, 3'd1, 0, 0, 0, 0);
    run("R4 user mode", mk(9'd0), 64'h100, 64'h1, 0, 1, 3'd1, 0, 0, 0, 0);
    run("R4 seg 0", mk(9'd0), 64'h100, 64'h1, 1, 1, 3'd0, 0, 0, 0, 0);
    run("R4 seg 6", mk(9'd0), 64'h100, 64'h1, 1, 1, 3'd6, 0, 0, 0, 0);
    run("R6 odd strict", mk(9'd1), 64'h100, 64'h1, 1, 1, 3'd2, 0, 0, 0, 0);
    run("R6 odd allowed", mk(9'd1), 64'h100, 64'h7788, 1, 1, 3'd2, 0, 0, 1, 0);
  endtask

  task automatic t_priority;
    run("R10 all causes", mk(9'd1), 64'h100, 64'h1, 0, 0, 3'd5, 0, 0, 0, 0);
    run("R10 priv over align", mk(9'd1), 64'h100, 64'h1, 0, 1, 3'd5, 0, 0, 0, 0);
    run("R10 align last", mk(9'd1), 64'h100, 64'h1, 1, 1, 3'd1, 0, 0, 0, 0);
  endtask

  task automatic t_lane7;
    run("R9 wrap little", mk(9'd7), 64'h800, 64'hABCD, 1, 1, 3'd1, 0, 0, 1, 1);
    run("R9 split little", mk(9'd7), 64'h800, 64'hABCD, 1, 1, 3'd2, 0, 0, 1, 0);
    run("R9 wrap big", mk(9'h1FB), 64'h808, 64'h9876, 1, 1, 3'd3, 1, 0, 1, 1);
    run("R9 split big", mk(9'h1FB), 64'h808, 64'h9876, 1, 1, 3'd3, 1, 1, 1, 0);
  endtask

  task automatic t_nohit;
    run("R1 wrong major", {6'b011001, mk(9'd0)}[31:0] ^ 32'h0400_0000, 64'h100, 64'h1, 1, 0, 3'd0, 0, 0, 0, 0);
    run("R1 wrong sub", mk(9'd0) ^ 32'h0000_0200, 64'h100, 64'h1, 1, 1, 3'd1, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_xlat;
    t_endian;
    t_exc;
    t_priority;
    t_lane7;
    t_nohit;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule